// File: doc/BRIEF.md
# UART Host Register Block

This block is the processor-facing register file of a 16550-compatible serial port. It has no serializer. Software reaches eight byte-wide registers through a 3-bit offset with separate read and write strobes. Received characters come in as a byte stream and wait in a receive queue. Bytes written to the transmit data register leave on a byte-stream output. When loopback is selected, they go back into the receive queue instead. Baud timing, shift registers, parity and framing belong to the neighbouring logic. The block only holds the divisor value that such logic would use.

The block holds the divisor latch, interrupt enable, FIFO control, line control, modem control, line status, modem status and scratch registers. A fixed-priority cause encoder produces the interrupt identification value and the single interrupt line. The transmitter always reports ready. A "transmit empty" interrupt is armed by every data write and disarmed when an identification read reports it. The receive queue holds one byte until software enables the FIFO, and sixteen bytes after that.

Register offsets follow the standard map:
- 0: data, or divisor low byte when LCR bit 7 is set.
- 1: interrupt enable, or divisor high byte when LCR bit 7 is set.
- 2: IIR on read, FCR on write.
- 3: LCR.
- 4: MCR.
- 5: LSR.
- 6: MSR.
- 7: scratch.

Top module: `uart_regfile`

## Requirements
- R1: After reset the divisor reads 12 (low byte 0x0C, high byte 0x00), IER, LCR, MCR and MSR read 0, IIR reads 0x01, LSR reads 0x60, irq is low and tx_valid is low.
- R2: While LCR bit 7 is set, offsets 0 and 1 read and write the divisor low and high bytes. The data register, the IER, the transmit stream and the receive queue are left untouched.
- R3: A data write (offset 0, LCR bit 7 clear, MCR bit 4 clear) puts the byte on tx_byte with tx_valid high for exactly the next cycle. Every data write, in loopback too, arms the transmit-empty interrupt flag.
- R4: With the FIFO disabled the receive queue holds one byte. A push into a full queue sets LSR bit 1 (overrun) and drops the byte. A data read pops the oldest byte. A data read of an empty queue returns 0xFF and changes nothing.
- R5: Writing FCR with bit 0 changed empties the queue and sets its depth to 16 (enabling) or 1 (disabling). With bit 0 set, FCR bit 1 empties the queue. With bit 0 clear, FCR is stored as 0; otherwise only bits 7:6, 3 and 0 are kept. A seventeenth byte into a full 16-byte queue sets overrun.
- R6: An LSR read returns bits 6 and 5 set, bit 0 equal to "queue not empty" and bit 1 equal to overrun. Overrun is cleared after the read unless a new overrun occurs in the same cycle.
- R7: IIR bits 3:0 give the highest active cause. The causes, from highest to lowest:
  - 0x6: overrun with IER bit 2 set.
  - 0xC: queue not empty with IER bit 0 set.
  - 0x2: transmit-empty flag with IER bit 1 set.
  - 0x0: any MSR bit 3:0 set with IER bit 3 set.
  - 0x1: none of the above.

  IIR bits 7:6 read 11 while FCR bit 0 is set, else 00.
- R8: An IIR read that reports 0x2 clears the transmit-empty flag. An IIR read that reports any other cause leaves the flag set.
- R9: An IER write keeps bits 3:0 and zeroes 7:4. An MCR write keeps bits 4:0 and zeroes 7:5.
- R10: In loopback (MCR bit 4), data writes push into the receive queue (with overrun as in R4/R5) and produce no tx_valid. Bytes on the receive stream are discarded.
- R11: On an MCR write, the MSR status bits 7:4 (DCD, RI, DSR, CTS) become OUT2, OUT1, DTR, RTS (MCR bits 3, 2, 0, 1) in loopback, and 0 otherwise. MSR bit 0, 1 or 3 is set when CTS, DSR or DCD changes. Bit 2 is set when RI falls. Delta bits already set stay set.
- R12: An MSR read returns the register, then clears bits 3:0.
- R13: irq is high exactly when the R7 cause is not 0x1. It follows register state with no extra delay.
- R14: LCR and scratch read back the full byte last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe; side effects apply at the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset and state |
| rx_valid | input | 1 | Receive stream byte present this cycle |
| rx_byte | input | 8 | Receive stream byte |
| tx_valid | output | 1 | Transmit stream byte present |
| tx_byte | output | 8 | Transmit stream byte |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational from the state before the clock edge. The bench therefore samples bus_rdata in the same cycle as the read strobe, just before the rising edge. The side effects of that read (pop, overrun clear, delta clear, flag clear) show up in accesses made from the next cycle on. tx_valid comes from a register and is due in the cycle after the write edge. irq is decoded from state and changes right after the edge that updates that state. Both are compared one nanosecond after every rising edge against the bench model, which is stepped at that same edge.

// File: rtl/uart_regfile.sv
module uart_regfile #(
  parameter int REF_HZ     = 1843200,
  parameter int BAUD       = 9600,
  parameter int FIFO_DEPTH = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  output logic       irq
);

  localparam int         DIVISOR  = REF_HZ / BAUD / 16;
  localparam logic [15:0] DIV_RST = 16'(DIVISOR);
  localparam int         PW       = $clog2(FIFO_DEPTH);
  localparam logic [PW:0] FULL_CAP = (PW+1)'(FIFO_DEPTH);
  localparam logic [PW:0] ONE_CAP  = (PW+1)'(1);

  localparam logic [3:0] C_LINE = 4'h6;
  localparam logic [3:0] C_RXD  = 4'hC;
  localparam logic [3:0] C_THR  = 4'h2;
  localparam logic [3:0] C_MDM  = 4'h0;
  localparam logic [3:0] C_NONE = 4'h1;

  logic [7:0] dll, dlh, lcr, scr, fcr, msr_q;
  logic [3:0] ier;
  logic [4:0] mcr;
  logic       oe, thre_pend, deep;
  logic [7:0] mem [FIFO_DEPTH];
  logic [PW-1:0] rptr, wptr;
  logic [PW:0]   cnt;

  wire dlab  = lcr[7];
  wire loop  = mcr[4];
  wire empty = (cnt == '0);
  wire [PW:0] cap = deep ? FULL_CAP : ONE_CAP;

  wire wr_dat = bus_wr && bus_addr == 3'd0 && !dlab;
  wire wr_dll = bus_wr && bus_addr == 3'd0 &&  dlab;
  wire wr_ier = bus_wr && bus_addr == 3'd1 && !dlab;
  wire wr_dlh = bus_wr && bus_addr == 3'd1 &&  dlab;
  wire wr_fcr = bus_wr && bus_addr == 3'd2;
  wire wr_lcr = bus_wr && bus_addr == 3'd3;
  wire wr_mcr = bus_wr && bus_addr == 3'd4;
  wire wr_scr = bus_wr && bus_addr == 3'd7;
  wire rd_dat = bus_rd && bus_addr == 3'd0 && !dlab;
  wire rd_iir = bus_rd && bus_addr == 3'd2;
  wire rd_lsr = bus_rd && bus_addr == 3'd5;
  wire rd_msr = bus_rd && bus_addr == 3'd6;

  logic [3:0] cause;
  always_comb begin
    if (oe && ier[2])                 cause = C_LINE;
    else if (!empty && ier[0])        cause = C_RXD;
    else if (thre_pend && ier[1])     cause = C_THR;
    else if (|msr_q[3:0] && ier[3])   cause = C_MDM;
    else                              cause = C_NONE;
  end

  assign irq = (cause != C_NONE);

  wire [7:0] iir_val = {fcr[0] ? 2'b11 : 2'b00, 2'b00, cause};
  wire [7:0] lsr_val = {1'b0, 1'b1, 1'b1, 3'b000, oe, !empty};

  always_comb begin
    case (bus_addr)
      3'd0:    bus_rdata = dlab ? dll : (empty ? 8'hFF : mem[rptr]);
      3'd1:    bus_rdata = dlab ? dlh : {4'h0, ier};
      3'd2:    bus_rdata = iir_val;
      3'd3:    bus_rdata = lcr;
      3'd4:    bus_rdata = {3'b000, mcr};
      3'd5:    bus_rdata = lsr_val;
      3'd6:    bus_rdata = msr_q;
      default: bus_rdata = scr;
    endcase
  end

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p, input logic [PW:0] c);
    return ({1'b0, p} == c - ONE_CAP) ? '0 : p + 1'b1;
  endfunction

  wire        pop       = rd_dat && !empty;
  wire        push      = loop ? wr_dat : rx_valid;
  wire [7:0]  push_byte = loop ? bus_wdata : rx_byte;
  wire [PW:0] cnt_left  = cnt - (PW+1)'(pop);
  wire        room      = (cnt_left != cap);
  wire        accept    = push && room;
  wire        overrun   = push && !room;
  wire        flush     = wr_fcr && ((bus_wdata[0] ^ fcr[0]) || (bus_wdata[0] && bus_wdata[1]));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
      deep <= 1'b0;
    end else if (flush) begin
      rptr <= '0;
      wptr <= '0;
      cnt  <= '0;
      deep <= bus_wdata[0];
    end else begin
      if (pop)    rptr <= ptr_next(rptr, cap);
      if (accept) wptr <= ptr_next(wptr, cap);
      cnt <= cnt_left + (PW+1)'(accept);
    end
  end

  always_ff @(posedge clk) begin
    if (accept && !flush) mem[wptr] <= push_byte;
  end

  logic [3:0] st_new;
  always_comb begin
    st_new = 4'h0;
    if (bus_wdata[4]) st_new = {bus_wdata[3], bus_wdata[2], bus_wdata[0], bus_wdata[1]};
  end

  wire [3:0] delta_new = {msr_q[7] ^ st_new[3],
                          msr_q[6] & ~st_new[2],
                          msr_q[5] ^ st_new[1],
                          msr_q[4] ^ st_new[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dll       <= DIV_RST[7:0];
      dlh       <= DIV_RST[15:8];
      ier       <= '0;
      lcr       <= '0;
      mcr       <= '0;
      msr_q     <= '0;
      fcr       <= '0;
      scr       <= '0;
      oe        <= 1'b0;
      thre_pend <= 1'b0;
      tx_valid  <= 1'b0;
      tx_byte   <= '0;
    end else begin
      tx_valid <= wr_dat && !loop;
      if (wr_dat && !loop) tx_byte <= bus_wdata;
      if (wr_dll) dll <= bus_wdata;
      if (wr_dlh) dlh <= bus_wdata;
      if (wr_ier) ier <= bus_wdata[3:0];
      if (wr_lcr) lcr <= bus_wdata;
      if (wr_scr) scr <= bus_wdata;
      if (wr_fcr) fcr <= bus_wdata[0] ? (bus_wdata & 8'hC9) : 8'h00;
      if (wr_mcr) begin
        mcr   <= bus_wdata[4:0];
        msr_q <= {st_new, msr_q[3:0] | delta_new};
      end else if (rd_msr) begin
        msr_q[3:0] <= 4'h0;
      end
      oe        <= overrun || (oe && !rd_lsr);
      thre_pend <= wr_dat || (thre_pend && !(rd_iir && cause == C_THR));
    end
  end

endmodule

// File: rtl/uart_regfile_chk.sv
module uart_regfile_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [2:0]    bus_addr,
  input logic [7:0]    bus_rdata,
  input logic          tx_valid,
  input logic          irq,
  input logic          dlab,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] cap,
  input logic [7:0]    msr_q
);

  AST_LSR_TX_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5) |-> bus_rdata[6:5] == 2'b11); // R6

  AST_IRQ_VS_IIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2) |-> (irq == (bus_rdata[3:0] != 4'h1))); // R13

  AST_TX_FROM_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> $past(bus_wr && bus_addr == 3'd0 && !dlab)); // R3

  AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1 && !dlab) |-> bus_rdata[7:4] == 4'h0); // R9

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= cap); // R5

  AST_MSR_DELTA_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr && bus_addr == 3'd6) |=> msr_q[3:0] == 4'h0); // R12

  AST_EMPTY_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && !dlab && cnt == '0) |-> bus_rdata == 8'hFF); // R4

endmodule

bind uart_regfile uart_regfile_chk #(.CW(PW + 1)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_rd    (bus_rd),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .tx_valid  (tx_valid),
  .irq       (irq),
  .dlab      (lcr[7]),
  .cnt       (cnt),
  .cap       (cap),
  .msr_q     (msr_q)
);

// File: tb/uart_regfile_tb.sv
`timescale 1ns/100ps
module uart_regfile_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic       bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       rx_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       tx_valid;
  logic [7:0] tx_byte;
  logic       irq;

  always #2.5 clk = ~clk;

  uart_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .irq(irq)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [7:0] q[$];
  int         m_cap;
  logic [7:0] m_dll, m_dlh, m_lcr, m_scr, m_fcr, m_msr, m_txb;
  logic [3:0] m_ier;
  logic [4:0] m_mcr;
  bit         m_oe, m_thre, m_txv;

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] m_cause();
    if (m_oe && m_ier[2]) return 4'h6;
    if (q.size() > 0 && m_ier[0]) return 4'hC;
    if (m_thre && m_ier[1]) return 4'h2;
    if (m_msr[3:0] != 0 && m_ier[3]) return 4'h0;
    return 4'h1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0: return m_lcr[7] ? m_dll : (q.size() > 0 ? q[0] : 8'hFF);
      3'd1: return m_lcr[7] ? m_dlh : {4'h0, m_ier};
      3'd2: return {m_fcr[0] ? 2'b11 : 2'b00, 2'b00, m_cause()};
      3'd3: return m_lcr;
      3'd4: return {3'b000, m_mcr};
      3'd5: return {1'b0, 1'b1, 1'b1, 3'b000, m_oe, q.size() > 0};
      3'd6: return m_msr;
      default: return m_scr;
    endcase
  endfunction

  task automatic m_push(input logic [7:0] b);
    if (q.size() < m_cap) q.push_back(b);
    else m_oe = 1'b1;
  endtask

  task automatic model_step(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d,
                            input bit rv, input logic [7:0] rb);
    bit dlab = m_lcr[7];
    bit loop = m_mcr[4];
    logic [3:0] c = m_cause();
    m_txv = 1'b0;
    if (r) begin
      if (a == 3'd0 && !dlab && q.size() > 0) void'(q.pop_front());
      if (a == 3'd2 && c == 4'h2) m_thre = 1'b0;
      if (a == 3'd5) m_oe = 1'b0;
      if (a == 3'd6) m_msr[3:0] = 4'h0;
    end
    if (w) begin
      case (a)
        3'd0: if (dlab) m_dll = d;
              else begin
                m_thre = 1'b1;
                if (loop) m_push(d);
                else begin m_txv = 1'b1; m_txb = d; end
              end
        3'd1: if (dlab) m_dlh = d; else m_ier = d[3:0];
        3'd2: begin
          if (d[0] != m_fcr[0]) begin q.delete(); m_cap = d[0] ? 16 : 1; end
          if (!d[0]) m_fcr = 8'h00;
          else begin
            if (d[1]) begin q.delete(); m_cap = 16; end
            m_fcr = d & 8'hC9;
          end
        end
        3'd3: m_lcr = d;
        3'd4: begin
          bit cts = 0, dsr = 0, ri = 0, dcd = 0;
          if (d[4]) begin cts = d[1]; dsr = d[0]; ri = d[2]; dcd = d[3]; end
          if (cts != m_msr[4]) m_msr[0] = 1'b1;
          if (dsr != m_msr[5]) m_msr[1] = 1'b1;
          if (m_msr[6] && !ri) m_msr[2] = 1'b1;
          if (dcd != m_msr[7]) m_msr[3] = 1'b1;
          m_msr[7:4] = {dcd, ri, dsr, cts};
          m_mcr = d[4:0];
        end
        3'd7: m_scr = d;
        default: ;
      endcase
    end
    if (rv && !loop) m_push(rb);
  endtask

  task automatic op(input bit w, input bit r, input logic [2:0] a, input logic [7:0] d,
                    input bit rv, input logic [7:0] rb, input string tag);
    logic [7:0] e;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; rx_valid = rv; rx_byte = rb;
    #1;
    if (r) begin
      e = exp_read(a);
      chk(bus_rdata == e, tag, "rdata", int'(bus_rdata), int'(e));
    end
    @(posedge clk);
    model_step(w, r, a, d, rv, rb);
    #1;
    chk(irq == (m_cause() != 4'h1), "R13", "irq", int'(irq), int'(m_cause() != 4'h1));
    chk(tx_valid == m_txv, "R3/R10", "tx_valid", int'(tx_valid), int'(m_txv));
    if (m_txv) chk(tx_byte == m_txb, "R3", "tx_byte", int'(tx_byte), int'(m_txb));
    bus_wr = 1'b0; bus_rd = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d, 1'b0, 8'h00, "");
  endtask
  task automatic rd(input logic [2:0] a, input string tag);
    op(1'b0, 1'b1, a, 8'h00, 1'b0, 8'h00, tag);
  endtask
  task automatic rxb(input logic [7:0] b);
    op(1'b0, 1'b0, 3'd0, 8'h00, 1'b1, b, "");
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_cap = 1; m_dll = 8'h0C; m_dlh = 8'h00; m_lcr = 0; m_scr = 0; m_fcr = 0; m_msr = 0;
    m_ier = 0; m_mcr = 0; m_oe = 0; m_thre = 0; m_txv = 0; m_txb = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk(irq == 1'b0, "R1", "irq after reset", int'(irq), 0);
    chk(tx_valid == 1'b0, "R1", "tx_valid after reset", int'(tx_valid), 0);

    // R1 reset values
    rd(3'd2, "R1"); rd(3'd5, "R1"); rd(3'd1, "R1"); rd(3'd4, "R1"); rd(3'd6, "R1"); rd(3'd3, "R1");
    wr(3'd3, 8'h80);
    rd(3'd0, "R1"); rd(3'd1, "R1");
    // R2 divisor access
    wr(3'd0, 8'h34); wr(3'd1, 8'h12);
    rd(3'd0, "R2"); rd(3'd1, "R2");
    wr(3'd3, 8'h03);
    rd(3'd1, "R2"); rd(3'd5, "R2");
    // R9 IER mask
    wr(3'd1, 8'hFF); rd(3'd1, "R9");
    wr(3'd1, 8'h00);
    // R14 scratch and LCR
    wr(3'd7, 8'hA5); rd(3'd7, "R14");
    wr(3'd3, 8'h1B); rd(3'd3, "R14");
    wr(3'd3, 8'h03);
    // R4 empty read
    rd(3'd0, "R4");
    // R3 / R8 transmit
    wr(3'd1, 8'h02);
    wr(3'd0, 8'h41);
    rd(3'd2, "R8"); rd(3'd2, "R8");
    // R4 / R6 / R7 one-byte queue
    rxb(8'h11); rd(3'd5, "R6"); rd(3'd0, "R4");
    rxb(8'h22); rxb(8'h33);
    wr(3'd1, 8'h07);
    rd(3'd2, "R7"); rd(3'd5, "R6"); rd(3'd5, "R6"); rd(3'd2, "R7");
    rd(3'd0, "R4"); rd(3'd0, "R4");
    // R8 lower-priority flag survives
    wr(3'd0, 8'h55); rxb(8'h66);
    rd(3'd2, "R8"); rd(3'd0, "R4"); rd(3'd2, "R8"); rd(3'd2, "R8");
    // R5 sixteen-deep FIFO
    wr(3'd2, 8'hC1); rd(3'd2, "R5");
    for (int i = 0; i < 17; i++) rxb(8'(8'h80 + i));
    rd(3'd5, "R5"); rd(3'd2, "R7");
    for (int i = 0; i < 17; i++) rd(3'd0, "R5");
    rxb(8'hA1); rxb(8'hA2); rxb(8'hA3);
    wr(3'd2, 8'hC3);
    rd(3'd5, "R5"); rd(3'd2, "R5");
    rxb(8'h01); rxb(8'h02);
    wr(3'd2, 8'h00);
    rd(3'd5, "R5");
    rxb(8'h07); rxb(8'h08);
    rd(3'd2, "R5"); rd(3'd5, "R5"); rd(3'd0, "R5"); rd(3'd0, "R5");
    // R11 / R12 loopback modem status
    wr(3'd1, 8'h08);
    wr(3'd4, 8'h13);
    rd(3'd2, "R7"); rd(3'd6, "R11"); rd(3'd6, "R12"); rd(3'd2, "R13");
    wr(3'd4, 8'h1C); rd(3'd6, "R11");
    wr(3'd4, 8'h10); rd(3'd6, "R11");
    wr(3'd4, 8'hFF); rd(3'd4, "R9"); rd(3'd6, "R11");
    // R10 loopback data path
    wr(3'd1, 8'h01);
    wr(3'd0, 8'h5A);
    rd(3'd5, "R10");
    rxb(8'h77);
    rd(3'd0, "R10"); rd(3'd5, "R10");
    wr(3'd0, 8'h01); wr(3'd0, 8'h02);
    rd(3'd5, "R10"); rd(3'd0, "R10");
    wr(3'd4, 8'h03);
    rd(3'd6, "R11"); rd(3'd6, "R12");
    rxb(8'h99); rd(3'd0, "R10");
    repeat (3) op(1'b0, 1'b0, 3'd0, 8'h00, 1'b0, 8'h00, "");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule